// File: doc/BRIEF.md
# Bitwise Three-Input Lookup Unit

This unit evaluates an arbitrary Boolean function of three operands, one bit position at a time. Each result bit is read from an 8-entry truth table. The entry is chosen by the three operand bits at that position. One of the operands is the old value of the destination register, so the function can merge new data into what the destination already holds.

The truth table comes from one of two sources. In immediate mode, one table serves the whole word. It is assembled from two instruction fields: a 5-bit low part and a 3-bit high part. In register mode, every byte lane of the result has its own table, read from the matching byte of a fourth operand. With the default 64-bit width this gives eight independent functions. The two modes feed the operand bits into the table index in different orders.

The datapath is combinational. The result and a valid flag are captured in an output register that has a synchronous active-high reset, so the latency is one cycle.

Top module: `tri_lut_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next `out_valid` is 0 and the next `result` is all zeros.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock. A result for operands accepted at edge n appears after edge n.
- R3: Immediate mode (`mode`=0). Result bit i is table bit k, where k = 4*`opd_q`[i] + 2*`opd_p`[i] + `opd_dst`[i]. Table bit 0 is the least significant bit.
- R4: The immediate table is formed as {`imm_hi`, `imm_lo`}. `imm_lo` supplies table bits 4..0 and `imm_hi` supplies table bits 7..5.
- R5: Register mode (`mode`=1). Result bit i uses the table `opd_tbl`[8j+7:8j], where j = i/8. Its index is k = 4*`opd_dst`[i] + 2*`opd_p`[i] + `opd_q`[i].
- R6: In immediate mode `opd_tbl` has no effect on `result`. In register mode `imm_lo` and `imm_hi` have no effect on `result`.
- R7: A table of 8'h00 gives an all-zero result. A table of 8'hFF gives an all-ones result, whatever the operands are.
- R8: When `in_valid` is 0 at an edge, `result` keeps its previous value.
- R9: In immediate mode, table 8'hAA returns `opd_dst`, table 8'hCC returns `opd_p`, and table 8'hF0 returns `opd_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and table are presented this cycle |
| mode | input | 1 | Table source: 0 = immediate, 1 = per-lane register |
| imm_lo | input | 5 | Immediate table bits 4..0 |
| imm_hi | input | 3 | Immediate table bits 7..5 |
| opd_dst | input | XLEN | Old destination value (third input) |
| opd_p | input | XLEN | First source operand |
| opd_q | input | XLEN | Second source operand |
| opd_tbl | input | XLEN | Per-lane truth tables for register mode |
| out_valid | output | 1 | Registered valid flag |
| result | output | XLEN | Registered lookup result |

## Verification
The bench checks operand order with the pass-through tables. A design that swaps the roles of the index bits returns the wrong operand for 8'hAA, 8'hCC or 8'hF0.

It also checks register mode with a different table in every lane. A lane-selection slip, such as using lane 0's table everywhere or an off-by-one byte offset, corrupts the upper lanes. A design that reused the immediate index order in register mode fails for any non-symmetric table.

Further cases cover the constant tables 8'h00 and 8'hFF, split immediates that set only the high field, and changes to the unused table source. A design that mis-splices the immediate fields, or leaks the unused source into the result, shows up in these cases.

Finally, the bench holds `in_valid` low while the inputs change. This catches a result register that loads without a valid input.

// File: rtl/tri_lut_pkg.sv
package tri_lut_pkg;
  typedef enum logic {
    TBL_IMM = 1'b0,
    TBL_REG = 1'b1
  } tbl_src_e;

  localparam int TBL_W  = 8;
  localparam int IDX_W  = 3;
  localparam int LANE_W = 8;
endpackage

// File: rtl/tri_lut_cell.sv
module tri_lut_cell
  import tri_lut_pkg::*;
(
  input  logic [TBL_W-1:0] table_bits,
  input  logic [IDX_W-1:0] sel,
  output logic             bit_out
);
  always_comb bit_out = table_bits[sel];
endmodule

// File: rtl/tri_lut_lane.sv
module tri_lut_lane
  import tri_lut_pkg::*;
(
  input  tbl_src_e          src,
  input  logic [TBL_W-1:0]  imm_table,
  input  logic [TBL_W-1:0]  lane_table,
  input  logic [LANE_W-1:0] dst_b,
  input  logic [LANE_W-1:0] p_b,
  input  logic [LANE_W-1:0] q_b,
  output logic [LANE_W-1:0] lane_out
);
  logic [TBL_W-1:0] use_table;

  always_comb use_table = (src == TBL_REG) ? lane_table : imm_table;

  for (genvar k = 0; k < LANE_W; k++) begin : g_bit
    logic [IDX_W-1:0] sel_k;
    always_comb begin
      if (src == TBL_REG) sel_k = {dst_b[k], p_b[k], q_b[k]};
      else                sel_k = {q_b[k], p_b[k], dst_b[k]};
    end
    tri_lut_cell u_cell (
      .table_bits (use_table),
      .sel        (sel_k),
      .bit_out    (lane_out[k])
    );
  end
endmodule

// File: rtl/tri_lut_unit.sv
module tri_lut_unit
  import tri_lut_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            mode,
  input  logic [4:0]      imm_lo,
  input  logic [2:0]      imm_hi,
  input  logic [XLEN-1:0] opd_dst,
  input  logic [XLEN-1:0] opd_p,
  input  logic [XLEN-1:0] opd_q,
  input  logic [XLEN-1:0] opd_tbl,
  output logic            out_valid,
  output logic [XLEN-1:0] result
);
  localparam int LANES = XLEN / LANE_W;

  tbl_src_e         src;
  logic [TBL_W-1:0] imm_table;
  logic [XLEN-1:0]  comb_res;

  always_comb begin
    src       = tbl_src_e'(mode);
    imm_table = {imm_hi, imm_lo};
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    tri_lut_lane u_lane (
      .src        (src),
      .imm_table  (imm_table),
      .lane_table (opd_tbl[j*LANE_W +: LANE_W]),
      .dst_b      (opd_dst[j*LANE_W +: LANE_W]),
      .p_b        (opd_p[j*LANE_W +: LANE_W]),
      .q_b        (opd_q[j*LANE_W +: LANE_W]),
      .lane_out   (comb_res[j*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= comb_res;
    end
  end
endmodule

// File: rtl/tri_lut_unit_chk.sv
module tri_lut_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            mode,
  input logic [4:0]      imm_lo,
  input logic [2:0]      imm_hi,
  input logic [XLEN-1:0] opd_dst,
  input logic [XLEN-1:0] opd_p,
  input logic [XLEN-1:0] opd_q,
  input logic [XLEN-1:0] opd_tbl,
  input logic            out_valid,
  input logic [XLEN-1:0] result
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  assert_valid_lat_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  assert_zero_table_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode && {imm_hi, imm_lo} == 8'h00) |=> result == '0);

  assert_ones_table_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode && {imm_hi, imm_lo} == 8'hFF) |=> result == '1);

  assert_pass_dst_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode && {imm_hi, imm_lo} == 8'hAA) |=> result == $past(opd_dst));

  assert_reg_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode && opd_tbl == '0) |=> result == '0);

  assert_pass_q_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode && {imm_hi, imm_lo} == 8'hF0) |=> result == $past(opd_q));
endmodule

bind tri_lut_unit tri_lut_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
  .imm_lo(imm_lo), .imm_hi(imm_hi), .opd_dst(opd_dst), .opd_p(opd_p),
  .opd_q(opd_q), .opd_tbl(opd_tbl), .out_valid(out_valid), .result(result)
);

// File: tb/tri_lut_unit_test.sv
module tri_lut_unit_test;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic            mode = 1'b0;
  logic [4:0]      imm_lo = '0;
  logic [2:0]      imm_hi = '0;
  logic [XLEN-1:0] opd_dst = '0, opd_p = '0, opd_q = '0, opd_tbl = '0;
  logic            out_valid;
  logic [XLEN-1:0] result;

  logic [XLEN-1:0] exp_res = '0;
  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tri_lut_unit #(.XLEN(XLEN)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .imm_lo(imm_lo), .imm_hi(imm_hi), .opd_dst(opd_dst), .opd_p(opd_p),
    .opd_q(opd_q), .opd_tbl(opd_tbl), .out_valid(out_valid), .result(result)
  );

  function automatic logic [XLEN-1:0] model(input logic m, input logic [7:0] it,
      input logic [XLEN-1:0] d, input logic [XLEN-1:0] p,
      input logic [XLEN-1:0] q, input logic [XLEN-1:0] t);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) begin
      int k;
      logic [7:0] tb;
      if (m) begin
        k  = 4*int'(d[i]) + 2*int'(p[i]) + int'(q[i]);
        tb = t[(i/8)*8 +: 8];
      end else begin
        k  = 4*int'(q[i]) + 2*int'(p[i]) + int'(d[i]);
        tb = it;
      end
      r[i] = tb[k];
    end
    return r;
  endfunction

  function automatic logic [XLEN-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic check(input string tag, input logic [XLEN-1:0] got,
                       input logic [XLEN-1:0] want);
    n_checks++;
    if (got !== want) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  task automatic apply(input string tag, input logic v, input logic m,
      input logic [7:0] it, input logic [XLEN-1:0] d, input logic [XLEN-1:0] p,
      input logic [XLEN-1:0] q, input logic [XLEN-1:0] t);
    @(negedge clk);
    in_valid = v; mode = m; imm_hi = it[7:5]; imm_lo = it[4:0];
    opd_dst = d; opd_p = p; opd_q = q; opd_tbl = t;
    if (v) exp_res = model(m, it, d, p, q, t);
    @(posedge clk);
    #1;
    check({tag, " R2 valid"}, {{(XLEN-1){1'b0}}, out_valid}, {{(XLEN-1){1'b0}}, v});
    check(tag, result, exp_res);
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] d, p, q, t;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", {{(XLEN-1){1'b0}}, out_valid}, '0);
    check("R1 reset result", result, '0);
    @(negedge clk); rst = 1'b0;

    d = rnd64(); p = rnd64(); q = rnd64(); t = rnd64();
    apply("R7 table 00", 1, 0, 8'h00, d, p, q, t);
    check("R7 zeros", result, '0);
    apply("R7 table FF", 1, 0, 8'hFF, d, p, q, t);
    check("R7 ones", result, '1);
    apply("R9 pass dst", 1, 0, 8'hAA, d, p, q, t);
    check("R9 dst", result, d);
    apply("R9 pass p", 1, 0, 8'hCC, d, p, q, t);
    check("R9 p", result, p);
    apply("R9 pass q", 1, 0, 8'hF0, d, p, q, t);
    check("R9 q", result, q);
    apply("R3 index order", 1, 0, 8'h02, d, p, q, t);
    check("R3 minterm1", result, d & ~p & ~q);
    apply("R4 high field only", 1, 0, 8'hA0, d, p, q, t);
    apply("R4 low field only", 1, 0, 8'h1B, d, p, q, t);
    apply("R6 imm ignores tbl", 1, 0, 8'h96, d, p, q, ~t);
    check("R6 xor3", result, d ^ p ^ q);

    t = 64'hF0CC_AA00_FF96_E817;
    apply("R5 per-lane tables", 1, 1, 8'h00, d, p, q, t);
    apply("R5 lane pass", 1, 1, 8'h3C, d, p, q, {8{8'hF0}});
    check("R5 lane F0 gives dst", result, d);
    apply("R6 reg ignores imm", 1, 1, 8'hFF, d, p, q, {8{8'hAA}});
    check("R6 lane AA gives q", result, q);

    apply("R8 idle hold", 0, 0, 8'hFF, rnd64(), rnd64(), rnd64(), rnd64());
    apply("R8 idle hold2", 0, 1, 8'h00, rnd64(), rnd64(), rnd64(), rnd64());

    for (int n = 0; n < 400; n++) begin
      logic [7:0] it;
      it = 8'($urandom);
      apply("R3 R5 random", ($urandom % 5) != 0, 1'($urandom), it,
            rnd64(), rnd64(), rnd64(), rnd64());
    end

    @(negedge clk); rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); #1;
    check("R1 reset again", result, '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule